// File: doc/BRIEF.md
# Cascadable FIFO Depth-Expansion Chain

This block is a first-in first-out buffer built from several identical storage slices joined in a ring. Each slice owns a small memory and two ownership tokens: one that allows it to accept writes and one that allows it to supply reads. At any time only the slice that holds the write token stores incoming words, and only the slice that holds the read token returns words. A parameter selects the lead slice, which holds both tokens when reset is released. All other slices start with no token.

When a slice stores a word into its last location, it sends a one-clock pulse on its write hop line to the next slice in the ring. The next slice takes write ownership on the following clock. Read ownership moves the same way, on a separate line, when a slice returns the word from its last location. The last slice hands back to the first, so the chain behaves as one buffer of SLICES times DEPTH words.

The wrapper forms one full flag and one empty flag by combining the per-slice flags. Each slice reports its flag only while it owns the matching token or is in the middle of handing that token on. The whole design runs on one clock with a synchronous active-high reset.

Top module: `chain_fifo`

## Requirements
- R1: While reset is high and in the first cycle after it is released, empty is 1, full is 0 and rd_valid is 0; the slice with index LEAD holds both tokens.
- R2: Words come out in the order they were accepted. This holds across slice boundaries and across the wrap from the last slice back to the first.
- R3: The chain stores exactly SLICES*DEPTH words. When it holds that many, full is 1.
- R4: A write while full is 1 is ignored: no word is stored and the content read out later is unchanged.
- R5: A read while empty is 1 is ignored: rd_valid stays 0. empty is 1 whenever no word is stored.
- R6: A read accepted at a clock edge presents its word on rd_data with rd_valid=1 during the next cycle. rd_valid is 0 in every other cycle.
- R7: A write into a slice's last location passes write ownership to slice (index+1) mod SLICES on the next clock. full is 1 for exactly that one cycle, and a write offered in that cycle is ignored.
- R8: A read of a slice's last location passes read ownership to the next slice the same way. empty is 1 for exactly that one cycle.
- R9: A write hop and a read hop in the same cycle travel on separate lines. Both flags are 1 for one cycle, then both clear, and neither token is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request, taken at the clock edge when full is 0 |
| wr_data | input | DW | Word to store |
| full | output | 1 | Composite full / write-hop busy flag |
| rd_en | input | 1 | Read request, taken at the clock edge when empty is 0 |
| rd_data | output | DW | Word returned, valid when rd_valid is 1 |
| rd_valid | output | 1 | rd_data carries a word read at the previous edge |
| empty | output | 1 | Composite empty / read-hop busy flag |

## Verification
The hardest case to reach from the ports is a write hop and a read hop in the same clock. This needs the write pointer of one slice and the read pointer of an earlier slice to be on their last locations at once. A directed sequence builds exactly that occupancy from an empty chain: fifteen writes, then seven reads, then one cycle with both a write and a read. Random phases biased toward filling, toward draining, and balanced drive the chain through many wraps and repeated full and empty states. Every word read out is checked against a reference queue.

// File: rtl/chain_fifo_pkg.sv
package chain_fifo_pkg;
  // Ownership handoff lines between neighbouring slices
  typedef struct packed {
    logic wr;
    logic rd;
  } hop_t;
endpackage

// File: rtl/chain_fifo_token.sv
module chain_fifo_token #(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          is_lead,
  input  logic          step,
  input  logic          hop_in,
  output logic          own,
  output logic          hop_out,
  output logic [AW-1:0] ptr
);
  logic at_end;
  assign at_end = (ptr == AW'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      own     <= is_lead;
      ptr     <= '0;
      hop_out <= 1'b0;
    end else begin
      hop_out <= step && at_end;
      if (step) ptr <= at_end ? '0 : ptr + 1'b1;
      if (hop_in)              own <= 1'b1;
      else if (step && at_end) own <= 1'b0;
    end
  end

  // R7
  own_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(own) |-> hop_out);

  // R9
  hop_gain_chk: assert property (@(posedge clk) disable iff (rst)
    hop_in |=> own);
endmodule

// File: rtl/chain_fifo_ram.sv
module chain_fifo_ram #(
  parameter int DW    = 9,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/chain_fifo_slice.sv
module chain_fifo_slice
  import chain_fifo_pkg::*;
#(
  parameter int DW    = 9,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          is_lead,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  hop_t          hop_in,
  output hop_t          hop_out,
  output logic          full_o,
  output logic          empty_o,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          wown_o,
  output logic          rown_o
);
  logic [CW-1:0] count;
  logic [AW-1:0] wptr, rptr;
  logic          wown, rown, w_hop, r_hop;
  logic          wacc, racc, at_cap, at_zero;

  assign at_cap  = (count == CW'(DEPTH));
  assign at_zero = (count == '0);
  assign wacc    = wr_en && wown && !at_cap;
  assign racc    = rd_en && rown && !at_zero;

  // A slice reports a flag while it owns the token, or while it is handing it on
  assign full_o  = (wown && at_cap) || w_hop;
  assign empty_o = (rown && at_zero) || r_hop;

  assign hop_out.wr = w_hop;
  assign hop_out.rd = r_hop;
  assign wown_o     = wown;
  assign rown_o     = rown;

  chain_fifo_token #(.DEPTH(DEPTH)) u_wtok (
    .clk(clk), .rst(rst), .is_lead(is_lead), .step(wacc),
    .hop_in(hop_in.wr), .own(wown), .hop_out(w_hop), .ptr(wptr)
  );

  chain_fifo_token #(.DEPTH(DEPTH)) u_rtok (
    .clk(clk), .rst(rst), .is_lead(is_lead), .step(racc),
    .hop_in(hop_in.rd), .own(rown), .hop_out(r_hop), .ptr(rptr)
  );

  chain_fifo_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(wacc), .waddr(wptr), .wdata(wr_data),
    .re(racc), .raddr(rptr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= racc;
      case ({wacc, racc})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R3
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R4
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wown && at_cap && !rd_en) |=> (count == CW'(DEPTH)));

  // R5
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rown && at_zero) |=> !rd_valid);
endmodule

// File: rtl/chain_fifo.sv
module chain_fifo
  import chain_fifo_pkg::*;
#(
  parameter int DW     = 9,
  parameter int DEPTH  = 8,
  parameter int SLICES = 3,
  parameter int LEAD   = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          empty
);
  hop_t              hop   [SLICES];
  logic [DW-1:0]     sdata [SLICES];
  logic [SLICES-1:0] sfull, sempty, svld, wown, rown;

  for (genvar i = 0; i < SLICES; i++) begin : g_slice
    localparam int PREV = (i + SLICES - 1) % SLICES;
    chain_fifo_slice #(.DW(DW), .DEPTH(DEPTH)) u_slice (
      .clk(clk), .rst(rst), .is_lead(i == LEAD),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .hop_in(hop[PREV]), .hop_out(hop[i]),
      .full_o(sfull[i]), .empty_o(sempty[i]),
      .rd_data(sdata[i]), .rd_valid(svld[i]),
      .wown_o(wown[i]), .rown_o(rown[i])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < SLICES; k++) begin
      if (svld[k]) rd_data = rd_data | sdata[k];
    end
  end

  assign full     = |sfull;
  assign empty    = |sempty;
  assign rd_valid = |svld;

  // R7
  one_wtok_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wown));

  // R8
  one_rtok_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rown));

  // R2
  one_src_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(svld));

  // R6
  rd_lat_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en && !empty));
endmodule

// File: tb/chain_fifo_tb.sv
module chain_fifo_tb;
  localparam int DW = 9, DEPTH = 8, SLICES = 3, CAP = DEPTH * SLICES;

  logic          clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          full, empty, rd_valid;
  logic [DW-1:0] rd_data;

  int            n_cmp = 0, n_bad = 0;
  logic [DW-1:0] q [$];
  bit            wa, ra;

  always #4 clk = ~clk;

  chain_fifo #(.DW(DW), .DEPTH(DEPTH), .SLICES(SLICES), .LEAD(0)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .empty(empty)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One clock: decide acceptance from flags seen now, then check at the next negedge
  task automatic tick(input bit w, input bit r, output bit wacc, output bit racc);
    logic [DW-1:0] d, e;
    d = DW'($urandom);
    e = '0;
    wacc = w && !full;
    racc = r && !empty;
    wr_en = w; rd_en = r; wr_data = d;
    if (wacc) q.push_back(d);
    if (racc) begin
      if (q.size() == 0) chk(1'b0, "R5", "read accepted with nothing stored", 1, 0);
      else e = q.pop_front();
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk(rd_valid == racc, "R6", "rd_valid", int'(rd_valid), int'(racc));
    if (racc) chk(rd_data == e, "R2", "rd_data order", int'(rd_data), int'(e));
    if (q.size() == 0) chk(empty == 1'b1, "R5", "empty with nothing stored", int'(empty), 1);
    if (q.size() == CAP) chk(full == 1'b1, "R3", "full at capacity", int'(full), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int cnt;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    chk(empty == 1'b1, "R1", "empty in reset", int'(empty), 1);
    chk(full == 1'b0, "R1", "full in reset", int'(full), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(empty == 1'b1 && full == 1'b0 && rd_valid == 1'b0, "R1", "flags after reset",
        int'({empty, full, rd_valid}), 4);

    // R7: write hop after DEPTH writes
    for (int i = 0; i < DEPTH; i++) tick(1, 0, wa, ra);
    chk(q.size() == DEPTH, "R7", "writes taken before hop", q.size(), DEPTH);
    chk(full == 1'b1, "R7", "full during write hop", int'(full), 1);
    tick(1, 0, wa, ra);
    chk(full == 1'b0, "R7", "full after write hop", int'(full), 0);
    chk(q.size() == DEPTH, "R7", "write during hop ignored", q.size(), DEPTH);

    // R3: fill to capacity
    for (int i = 0; i < 4 * CAP && q.size() < CAP; i++) tick(1, 0, wa, ra);
    chk(q.size() == CAP, "R3", "words accepted", q.size(), CAP);
    for (int i = 0; i < 3; i++) begin
      tick(1, 0, wa, ra);
      chk(full == 1'b1, "R4", "full held under writes", int'(full), 1);
    end

    // R8: read hop after DEPTH reads
    for (int i = 0; i < DEPTH; i++) tick(0, 1, wa, ra);
    chk(q.size() == CAP - DEPTH, "R8", "reads taken before hop", q.size(), CAP - DEPTH);
    chk(empty == 1'b1, "R8", "empty during read hop", int'(empty), 1);
    tick(0, 1, wa, ra);
    chk(ra == 1'b0 && empty == 1'b0, "R8", "empty after read hop", int'(empty), 0);

    // Drain (R4: content unchanged by writes while full)
    for (int i = 0; i < 4 * CAP && q.size() > 0; i++) tick(0, 1, wa, ra);
    chk(q.size() == 0, "R4", "drained all stored words", q.size(), 0);
    for (int i = 0; i < 3; i++) begin
      tick(0, 1, wa, ra);
      chk(rd_valid == 1'b0, "R5", "read on empty", int'(rd_valid), 0);
    end

    // R9: write hop and read hop in the same cycle
    for (int i = 0; i < 4 * CAP && q.size() < 2 * DEPTH - 1; i++) tick(1, 0, wa, ra);
    cnt = 0;
    for (int i = 0; i < 4 * CAP && cnt < DEPTH - 1; i++) begin
      tick(0, 1, wa, ra);
      if (ra) cnt++;
    end
    tick(1, 1, wa, ra);
    chk(wa && ra, "R9", "both taken in hop cycle", int'({wa, ra}), 3);
    chk(full == 1'b1 && empty == 1'b1, "R9", "both flags during hops",
        int'({full, empty}), 3);
    tick(0, 0, wa, ra);
    chk(full == 1'b0 && empty == 1'b0, "R9", "both flags after hops",
        int'({full, empty}), 0);

    // Random phases: fill-biased, drain-biased, balanced
    for (int p = 0; p < 3; p++) begin
      int pw, pr;
      pw = (p == 0) ? 70 : (p == 1) ? 30 : 50;
      pr = 100 - pw;
      for (int i = 0; i < 1500; i++)
        tick(($urandom % 100) < pw, ($urandom % 100) < pr, wa, ra);
    end
    for (int i = 0; i < 8 * CAP && q.size() > 0; i++) tick(0, 1, wa, ra);
    chk(q.size() == 0, "R2", "final drain complete", q.size(), 0);
    tick(0, 0, wa, ra);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule